// File: doc/BRIEF.md
# Replicated Memory Ring Node

This block is one station on a one-way ring of nodes that each hold a full private copy of a shared word memory. A packet that comes in from the upstream neighbour is validated, stored into the local copy at the word address it carries, and sent on to the downstream neighbour one cycle later. A packet that comes back to the station that created it is taken off the ring. A packet that fails validation is also taken off the ring, and it can raise an error pulse.

The local host reads only the local copy, and reads never create ring traffic. A host write normally updates the local copy at once and is also queued for insertion into the outgoing stream as a one-word packet stamped with this node's identifier. Forwarded traffic always goes first. Queued insertions take whichever cycles the ring leaves free. The host can ask for a lock-style write, which leaves the local copy untouched until the packet has travelled the whole ring. The host can also mark a write for round-trip timing, in which case the node reports how long the packet took to come home.

Top module: `rmr_node`

## Requirements
- R1: A valid upstream packet that passes validation and carries a source other than NODE_ID (default 8'h05) is sent out unchanged on the tx port on the cycle after it is accepted. Its data words 0..len-1 are written to local words addr..addr+len-1.
- R2: A valid upstream packet whose source equals NODE_ID is never forwarded. If its lock flag is clear, it writes nothing.
- R3: A packet fails validation when len is 0, when len exceeds MAX_WORDS, or when its check byte mismatches. A failed packet is neither forwarded nor written. err_irq pulses high for one cycle on the following cycle only if err_arm was high when the packet was accepted.
- R4: An accepted host write without the lock flag updates the local word at once. It is later sent as a packet with src=NODE_ID, len=1, data word 0 = the written data, and the lock and monitor flags copied from the write.
- R5: An insertion never launches in a cycle that launches a forward. At most FQ_DEPTH (default 4) writes wait in the queue. host_full is high while the queue is full, and a host write made while host_full is high is ignored: no memory update and no packet.
- R6: A host write with the lock flag leaves the local word unchanged until its own packet returns on rx. The word is written when that packet is accepted.
- R7: When an own packet with the monitor flag returns, mon_done pulses on the next cycle. mon_lat then equals the count of rising edges after the edge that launched the packet, up to and including the edge that accepted its return.
- R8: host_rdata presents the local word at host_raddr on the cycle after host_re, and reads produce no tx activity.
- R9: When an upstream write and a host write target the same word in the same cycle, the upstream data is the value kept.
- R10: Payloads of 1 to MAX_WORDS (default 16) 32-bit words are accepted, and word addresses wrap modulo 2^ADDR_W (default 64 words).
- R11: After reset, tx_valid, err_irq, mon_done and host_full are low and every local word reads as zero.
- R12: The check byte is the XOR of these bytes: src, {6'b0,lock,mon}, the low and high bytes of the address zero-extended to 16 bits, len zero-extended to 8 bits, and all four bytes of every data word with index below len.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Upstream packet present |
| rx_src | input | 8 | Creator node identifier |
| rx_lock | input | 1 | Lock-write flag |
| rx_mon | input | 1 | Round-trip monitor flag |
| rx_addr | input | ADDR_W | First word address |
| rx_len | input | LEN_W | Payload length in words |
| rx_data | input | 32*MAX_WORDS | Payload, word i at bits 32i+31:32i |
| rx_chk | input | 8 | Check byte |
| tx_valid | output | 1 | Downstream packet present |
| tx_src | output | 8 | Creator node identifier |
| tx_lock | output | 1 | Lock-write flag |
| tx_mon | output | 1 | Round-trip monitor flag |
| tx_addr | output | ADDR_W | First word address |
| tx_len | output | LEN_W | Payload length in words |
| tx_data | output | 32*MAX_WORDS | Payload |
| tx_chk | output | 8 | Check byte |
| host_we | input | 1 | Host write request |
| host_lock | input | 1 | Lock-style write |
| host_mon | input | 1 | Time the round trip |
| host_waddr | input | ADDR_W | Host write word address |
| host_wdata | input | 32 | Host write data |
| host_full | output | 1 | Insertion queue full |
| host_re | input | 1 | Host read request |
| host_raddr | input | ADDR_W | Host read word address |
| host_rdata | output | 32 | Read data, one cycle after host_re |
| err_arm | input | 1 | Enables the error pulse |
| err_irq | output | 1 | Dropped-packet error pulse |
| mon_done | output | 1 | Monitored packet came home |
| mon_lat | output | LAT_W | Measured round trip in cycles |

## Verification
A wrong classification shows up on tx the very next cycle. A valid foreign packet then goes missing, or an own or corrupted packet reappears, or err_irq fires with the wrong arming. A bad memory write, whether it misses the wrap, covers the wrong length, or lets the host win a collision, shows only later, through host_rdata one cycle after a read. For that reason every touched window is read back word by word. A broken queue or lock path shows as a wrong count of own-source packets after the ring goes quiet, or as a lock-written word changing before its packet returns. The mon_lat value exposes any timestamp taken on the wrong edge.

// File: rtl/rmr_pkg.sv
package rmr_pkg;

  typedef enum logic [1:0] {
    RX_IDLE = 2'd0,
    RX_FWD  = 2'd1,
    RX_OWN  = 2'd2,
    RX_BAD  = 2'd3
  } rx_kind_e;

  function automatic logic [7:0] fold8(input logic [31:0] w);
    return w[7:0] ^ w[15:8] ^ w[23:16] ^ w[31:24];
  endfunction

endpackage

// File: rtl/rmr_pkt_chk.sv
module rmr_pkt_chk #(
  parameter int ADDR_W    = 6,
  parameter int MAX_WORDS = 16,
  parameter int LEN_W     = 5
) (
  input  logic [7:0]              src,
  input  logic                    lock,
  input  logic                    mon,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LEN_W-1:0]        len,
  input  logic [32*MAX_WORDS-1:0] data,
  output logic [7:0]              chk
);
  always_comb begin
    logic [15:0] a16;
    logic [7:0]  l8;
    logic [31:0] wx;
    a16 = 16'(addr);
    l8  = 8'(len);
    wx  = '0;
    for (int i = 0; i < MAX_WORDS; i++) begin
      if (i < int'(len)) wx ^= data[i*32 +: 32];
    end
    chk = src ^ {6'b0, lock, mon} ^ a16[7:0] ^ a16[15:8] ^ l8 ^ rmr_pkg::fold8(wx);
  end
endmodule

// File: rtl/rmr_rx_classify.sv
module rmr_rx_classify #(
  parameter logic [7:0] NODE_ID   = 8'h05,
  parameter int         MAX_WORDS = 16,
  parameter int         LEN_W     = 5
) (
  input  logic                   valid,
  input  logic [7:0]             src,
  input  logic [LEN_W-1:0]       len,
  input  logic [7:0]             chk_rx,
  input  logic [7:0]             chk_calc,
  output rmr_pkg::rx_kind_e      kind
);
  logic len_ok;
  assign len_ok = (len != '0) && (int'(len) <= MAX_WORDS);

  always_comb begin
    if (!valid)                            kind = rmr_pkg::RX_IDLE;
    else if (!len_ok || chk_rx != chk_calc) kind = rmr_pkg::RX_BAD;
    else if (src == NODE_ID)               kind = rmr_pkg::RX_OWN;
    else                                   kind = rmr_pkg::RX_FWD;
  end
endmodule

// File: rtl/rmr_store.sv
module rmr_store #(
  parameter int ADDR_W    = 6,
  parameter int MAX_WORDS = 16,
  parameter int LEN_W     = 5,
  localparam int DEPTH    = 1 << ADDR_W,
  localparam int IDX_W    = $clog2(MAX_WORDS),
  localparam int CMP_W    = (ADDR_W > LEN_W) ? ADDR_W : LEN_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ring_we,
  input  logic [ADDR_W-1:0]       ring_addr,
  input  logic [LEN_W-1:0]        ring_len,
  input  logic [32*MAX_WORDS-1:0] ring_data,
  input  logic                    host_wr,
  input  logic [ADDR_W-1:0]       host_waddr,
  input  logic [31:0]             host_wdata,
  input  logic                    host_re,
  input  logic [ADDR_W-1:0]       host_raddr,
  output logic [31:0]             host_rdata,
  output logic                    host_lost
);
  logic [31:0]      mem  [DEPTH];
  logic [31:0]      rw   [MAX_WORDS];
  logic [31:0]      wdat [DEPTH];
  logic [DEPTH-1:0] hit;

  for (genvar w = 0; w < MAX_WORDS; w++) begin : g_unpack
    assign rw[w] = ring_data[w*32 +: 32];
  end

  // Each local word finds its offset inside the incoming burst (modulo depth).
  for (genvar j = 0; j < DEPTH; j++) begin : g_word
    logic [ADDR_W-1:0] off;
    assign off     = ADDR_W'(j) - ring_addr;
    assign hit[j]  = ring_we && (CMP_W'(off) < CMP_W'(ring_len));
    assign wdat[j] = rw[off[IDX_W-1:0]];
  end

  assign host_lost = host_wr && hit[host_waddr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int j = 0; j < DEPTH; j++) mem[j] <= '0;
    end else begin
      for (int j = 0; j < DEPTH; j++) begin
        if (hit[j])                                      mem[j] <= wdat[j];
        else if (host_wr && host_waddr == ADDR_W'(j))    mem[j] <= host_wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       host_rdata <= '0;
    else if (host_re) host_rdata <= mem[host_raddr];
  end
endmodule

// File: rtl/rmr_txq.sv
module rmr_txq #(
  parameter int W     = 40,
  parameter int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  logic [W-1:0]     slot [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;
  logic             do_push, do_pop;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (int'(p) == DEPTH - 1) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (count == '0);
  assign full    = (int'(count) == DEPTH);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = slot[rd_ptr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      for (int i = 0; i < DEPTH; i++) slot[i] <= '0;
    end else begin
      if (do_push) begin
        slot[wr_ptr] <= din;
        wr_ptr       <= bump(wr_ptr);
      end
      if (do_pop) rd_ptr <= bump(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/rmr_node.sv
module rmr_node #(
  parameter logic [7:0] NODE_ID   = 8'h05,
  parameter int         ADDR_W    = 6,
  parameter int         MAX_WORDS = 16,
  parameter int         FQ_DEPTH  = 4,
  parameter int         LAT_W     = 16,
  localparam int        LEN_W     = $clog2(MAX_WORDS + 1),
  localparam int        PW        = 32 * MAX_WORDS,
  localparam int        QW        = 2 + ADDR_W + 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [7:0]        rx_src,
  input  logic              rx_lock,
  input  logic              rx_mon,
  input  logic [ADDR_W-1:0] rx_addr,
  input  logic [LEN_W-1:0]  rx_len,
  input  logic [PW-1:0]     rx_data,
  input  logic [7:0]        rx_chk,
  output logic              tx_valid,
  output logic [7:0]        tx_src,
  output logic              tx_lock,
  output logic              tx_mon,
  output logic [ADDR_W-1:0] tx_addr,
  output logic [LEN_W-1:0]  tx_len,
  output logic [PW-1:0]     tx_data,
  output logic [7:0]        tx_chk,
  input  logic              host_we,
  input  logic              host_lock,
  input  logic              host_mon,
  input  logic [ADDR_W-1:0] host_waddr,
  input  logic [31:0]       host_wdata,
  output logic              host_full,
  input  logic              host_re,
  input  logic [ADDR_W-1:0] host_raddr,
  output logic [31:0]       host_rdata,
  input  logic              err_arm,
  output logic              err_irq,
  output logic              mon_done,
  output logic [LAT_W-1:0]  mon_lat
);
  // ---------------- upstream classification ----------------
  logic [7:0]        rx_calc;
  rmr_pkg::rx_kind_e rx_kind;
  logic              fwd_go, own_ret, rx_bad, ring_we;

  rmr_pkt_chk #(.ADDR_W(ADDR_W), .MAX_WORDS(MAX_WORDS), .LEN_W(LEN_W)) u_rx_chk (
    .src(rx_src), .lock(rx_lock), .mon(rx_mon), .addr(rx_addr),
    .len(rx_len), .data(rx_data), .chk(rx_calc)
  );

  rmr_rx_classify #(.NODE_ID(NODE_ID), .MAX_WORDS(MAX_WORDS), .LEN_W(LEN_W)) u_cls (
    .valid(rx_valid), .src(rx_src), .len(rx_len),
    .chk_rx(rx_chk), .chk_calc(rx_calc), .kind(rx_kind)
  );

  assign fwd_go  = (rx_kind == rmr_pkg::RX_FWD);
  assign own_ret = (rx_kind == rmr_pkg::RX_OWN);
  assign rx_bad  = (rx_kind == rmr_pkg::RX_BAD);
  // Foreign data is stored now; an own lock packet completes its deferred write.
  assign ring_we = fwd_go || (own_ret && rx_lock);

  // ---------------- host insertion queue ----------------
  logic              q_empty, q_full, host_acc, host_wr, ins_go, host_lost;
  logic [QW-1:0]     q_dout;
  logic              q_lock, q_mon;
  logic [ADDR_W-1:0] q_addr;
  logic [31:0]       q_data;

  assign host_acc = host_we && !q_full;
  assign host_wr  = host_acc && !host_lock;

  rmr_txq #(.W(QW), .DEPTH(FQ_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n),
    .push(host_acc), .din({host_lock, host_mon, host_waddr, host_wdata}),
    .pop(ins_go), .dout(q_dout), .empty(q_empty), .full(q_full)
  );

  assign {q_lock, q_mon, q_addr, q_data} = q_dout;
  assign ins_go    = !q_empty && !fwd_go;
  assign host_full = q_full;

  logic [PW-1:0]    ins_data;
  logic [LEN_W-1:0] ins_len;
  logic [7:0]       ins_chk;
  assign ins_data = PW'(q_data);
  assign ins_len  = LEN_W'(1);

  rmr_pkt_chk #(.ADDR_W(ADDR_W), .MAX_WORDS(MAX_WORDS), .LEN_W(LEN_W)) u_ins_chk (
    .src(NODE_ID), .lock(q_lock), .mon(q_mon), .addr(q_addr),
    .len(ins_len), .data(ins_data), .chk(ins_chk)
  );

  // ---------------- local copy ----------------
  rmr_store #(.ADDR_W(ADDR_W), .MAX_WORDS(MAX_WORDS), .LEN_W(LEN_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .ring_we(ring_we), .ring_addr(rx_addr), .ring_len(rx_len), .ring_data(rx_data),
    .host_wr(host_wr), .host_waddr(host_waddr), .host_wdata(host_wdata),
    .host_re(host_re), .host_raddr(host_raddr), .host_rdata(host_rdata),
    .host_lost(host_lost)
  );

  // ---------------- downstream register ----------------
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_valid <= 1'b0;
      tx_src   <= '0;
      tx_lock  <= 1'b0;
      tx_mon   <= 1'b0;
      tx_addr  <= '0;
      tx_len   <= '0;
      tx_data  <= '0;
      tx_chk   <= '0;
    end else begin
      tx_valid <= fwd_go || ins_go;
      if (fwd_go) begin
        tx_src  <= rx_src;
        tx_lock <= rx_lock;
        tx_mon  <= rx_mon;
        tx_addr <= rx_addr;
        tx_len  <= rx_len;
        tx_data <= rx_data;
        tx_chk  <= rx_chk;
      end else if (ins_go) begin
        tx_src  <= NODE_ID;
        tx_lock <= q_lock;
        tx_mon  <= q_mon;
        tx_addr <= q_addr;
        tx_len  <= ins_len;
        tx_data <= ins_data;
        tx_chk  <= ins_chk;
      end
    end
  end

  // ---------------- error pulse and round-trip timer ----------------
  logic [LAT_W-1:0] cyc_cnt, stamp;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_irq  <= 1'b0;
      mon_done <= 1'b0;
      mon_lat  <= '0;
      cyc_cnt  <= '0;
      stamp    <= '0;
    end else begin
      err_irq <= rx_bad && err_arm;
      cyc_cnt <= cyc_cnt + 1'b1;
      if (ins_go && q_mon) stamp <= cyc_cnt;
      mon_done <= own_ret && rx_mon;
      if (own_ret && rx_mon) mon_lat <= cyc_cnt - stamp;
    end
  end
endmodule

// File: rtl/rmr_node_chk.sv
module rmr_node_chk #(
  parameter logic [7:0] NODE_ID   = 8'h05,
  parameter int         MAX_WORDS = 16,
  parameter int         LEN_W     = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rx_valid,
  input logic [7:0]       rx_src,
  input logic             rx_mon,
  input logic             err_arm,
  input logic             err_irq,
  input logic             tx_valid,
  input logic [7:0]       tx_src,
  input logic [LEN_W-1:0] tx_len,
  input logic             fwd_go,
  input logic             ins_go,
  input logic             q_full,
  input logic             host_we,
  input logic             mon_done
);
  AST_TX_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_src != NODE_ID) |-> ($past(rx_valid) && $past(rx_src) == tx_src)); // R1

  AST_OWN_NOT_FWD: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_go |-> (rx_src != NODE_ID)); // R2

  AST_ERR_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    err_irq |-> ($past(err_arm) && $past(rx_valid))); // R3

  AST_INS_YIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    ins_go |-> !fwd_go); // R5

  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (q_full && host_we && !ins_go) |=> q_full); // R5

  AST_MON_OWN: assert property (@(posedge clk) disable iff (!rst_n)
    mon_done |-> ($past(rx_valid) && $past(rx_src) == NODE_ID && $past(rx_mon))); // R7

  AST_TX_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> (tx_len != '0 && int'(tx_len) <= MAX_WORDS)); // R10
endmodule

bind rmr_node rmr_node_chk #(.NODE_ID(NODE_ID), .MAX_WORDS(MAX_WORDS), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_src(rx_src), .rx_mon(rx_mon),
  .err_arm(err_arm), .err_irq(err_irq), .tx_valid(tx_valid), .tx_src(tx_src),
  .tx_len(tx_len), .fwd_go(fwd_go), .ins_go(ins_go), .q_full(q_full),
  .host_we(host_we), .mon_done(mon_done)
);

// File: tb/tb_rmr_node.sv
module tb_rmr_node;
  localparam logic [7:0] ME = 8'h05;
  localparam int AW = 6, DEP = 64, MW = 16, LW = 5, PW = 512;

  logic clk = 1'b0;
  logic rst_n;
  always #5 clk = ~clk;

  logic          rx_valid, rx_lock, rx_mon;
  logic [7:0]    rx_src, rx_chk;
  logic [AW-1:0] rx_addr;
  logic [LW-1:0] rx_len;
  logic [PW-1:0] rx_data;
  logic          tx_valid, tx_lock, tx_mon;
  logic [7:0]    tx_src, tx_chk;
  logic [AW-1:0] tx_addr;
  logic [LW-1:0] tx_len;
  logic [PW-1:0] tx_data;
  logic          host_we, host_lock, host_mon, host_full, host_re;
  logic [AW-1:0] host_waddr, host_raddr;
  logic [31:0]   host_wdata, host_rdata;
  logic          err_arm, err_irq, mon_done;
  logic [15:0]   mon_lat;

  rmr_node dut (.*);

  int total = 0, bad = 0, cyc = 0;
  logic [31:0] shadow [DEP];

  always @(posedge clk) cyc++;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] gen_word(input int seed, input int i);
    logic [7:0] s = 8'(seed);
    logic [7:0] k = 8'(i);
    return {s, k, s ^ 8'hA5, k * 8'd3 + 8'd1};
  endfunction

  function automatic logic [PW-1:0] gen_data(input int seed, input int n);
    logic [PW-1:0] d = '0;
    for (int i = 0; i < MW; i++)
      d[i*32 +: 32] = (i < n) ? gen_word(seed, i) : (32'hDEAD0000 | 32'(i));
    return d;
  endfunction

  // R12 restated: XOR all covered bytes one at a time.
  function automatic logic [7:0] ref_chk(input logic [7:0] s, input logic lk, input logic mn,
                                         input int a, input int n, input logic [PW-1:0] d);
    logic [7:0] r = s ^ {6'd0, lk, mn} ^ 8'(a) ^ 8'(a >> 8) ^ 8'(n);
    for (int i = 0; i < n && i < MW; i++)
      for (int b = 0; b < 4; b++) r ^= d[i*32 + b*8 +: 8];
    return r;
  endfunction

  task automatic drive_rx(input logic [7:0] s, input logic lk, input logic mn,
                          input int a, input int n, input logic [PW-1:0] d, input bit corrupt);
    rx_valid = 1'b1; rx_src = s; rx_lock = lk; rx_mon = mn;
    rx_addr = AW'(a); rx_len = LW'(n); rx_data = d;
    rx_chk = ref_chk(s, lk, mn, a, n, d) ^ (corrupt ? 8'h5A : 8'h00);
  endtask

  task automatic rd(input int a, input string tag, input logic [31:0] exp);
    @(negedge clk);
    host_re = 1'b1; host_raddr = AW'(a);
    @(negedge clk);
    host_re = 1'b0;
    check(host_rdata == exp, tag, "read word", 64'(host_rdata), 64'(exp));
    check(tx_valid == 1'b0, "R8", "tx idle during read", 64'(tx_valid), 64'd0);
  endtask

  // Vector table: kind 0 forwarded, 1 own drop, 2 validation drop.
  localparam int NV = 9;
  localparam logic [7:0] V_SRC  [NV] = '{8'd3, 8'd7, 8'd200, 8'h05, 8'd9, 8'd9, 8'd255, 8'd0, 8'd4};
  localparam int         V_ADDR [NV] = '{0, 8, 50, 30, 32, 36, 63, 16, 4};
  localparam int         V_LEN  [NV] = '{1, 4, 16, 2, 3, 0, 2, 8, 20};
  localparam int         V_SEED [NV] = '{11, 22, 33, 44, 55, 66, 77, 88, 99};
  localparam bit         V_BAD  [NV] = '{0, 0, 0, 0, 1, 0, 0, 0, 0};
  localparam int         V_KIND [NV] = '{0, 0, 0, 1, 2, 2, 0, 0, 2};

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog run did not finish actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [PW-1:0] d;
    logic [31:0]   rv;
    int            own_cnt, c1, exp_lat;
    logic [7:0]    cs, cc;
    logic          cl, cm;
    logic [AW-1:0] ca;
    logic [LW-1:0] cn;
    logic [PW-1:0] cd;

    rx_valid = 0; rx_src = 0; rx_lock = 0; rx_mon = 0; rx_addr = 0; rx_len = 0;
    rx_data = '0; rx_chk = 0; host_we = 0; host_lock = 0; host_mon = 0;
    host_waddr = 0; host_wdata = 0; host_re = 0; host_raddr = 0; err_arm = 1;
    for (int i = 0; i < DEP; i++) shadow[i] = '0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R11 reset state
    check(tx_valid == 0, "R11", "tx_valid", 64'(tx_valid), 0);
    check(err_irq == 0, "R11", "err_irq", 64'(err_irq), 0);
    check(mon_done == 0, "R11", "mon_done", 64'(mon_done), 0);
    check(host_full == 0, "R11", "host_full", 64'(host_full), 0);
    rd(0, "R11", 32'd0);
    rd(63, "R11", 32'd0);

    // Table walk: R1, R2, R3, R10, R12
    for (int v = 0; v < NV; v++) begin
      d = gen_data(V_SEED[v], V_LEN[v]);
      @(negedge clk);
      drive_rx(V_SRC[v], 1'b0, 1'b0, V_ADDR[v], V_LEN[v], d, V_BAD[v]);
      @(negedge clk);
      rx_valid = 0;
      if (V_KIND[v] == 0) begin
        check(tx_valid == 1, "R1", "forward valid", 64'(tx_valid), 1);
        check(tx_src == V_SRC[v] && tx_addr == AW'(V_ADDR[v]) && tx_len == LW'(V_LEN[v]),
              "R1", "forward header", {tx_src, 2'b0, tx_addr, 3'b0, tx_len}, 64'(V_SRC[v]));
        check(tx_data == d, "R1", "forward data", tx_data[63:0], d[63:0]);
        check(tx_chk == ref_chk(V_SRC[v], 0, 0, V_ADDR[v], V_LEN[v], d), "R12", "forward chk",
              64'(tx_chk), 64'(ref_chk(V_SRC[v], 0, 0, V_ADDR[v], V_LEN[v], d)));
        for (int k = 0; k < V_LEN[v]; k++) shadow[(V_ADDR[v] + k) % DEP] = gen_word(V_SEED[v], k);
      end else if (V_KIND[v] == 1) begin
        check(tx_valid == 0, "R2", "own packet removed", 64'(tx_valid), 0);
      end else begin
        check(tx_valid == 0, "R3", "bad packet removed", 64'(tx_valid), 0);
        check(err_irq == 1, "R3", "armed err pulse", 64'(err_irq), 1);
      end
      if (V_KIND[v] != 2) check(err_irq == 0, "R3", "no err on good", 64'(err_irq), 0);
      for (int k = 0; k < MW; k++)
        rd((V_ADDR[v] + k) % DEP, (V_LEN[v] == 16) ? "R10" : "R1", shadow[(V_ADDR[v] + k) % DEP]);
    end

    // R3 disarmed: corrupted packet drops silently
    err_arm = 0;
    d = gen_data(5, 2);
    @(negedge clk);
    drive_rx(8'd9, 0, 0, 44, 2, d, 1'b1);
    @(negedge clk);
    rx_valid = 0;
    check(err_irq == 0, "R3", "disarmed no pulse", 64'(err_irq), 0);
    check(tx_valid == 0, "R3", "disarmed dropped", 64'(tx_valid), 0);
    err_arm = 1;
    rd(44, "R3", shadow[44]);

    // R4 plain host write: immediate local update plus inserted packet
    @(negedge clk);
    host_we = 1; host_lock = 0; host_mon = 0; host_waddr = 12; host_wdata = 32'hCAFE0012;
    @(negedge clk);
    host_we = 0;
    check(tx_valid == 0, "R4", "no insert on accept edge", 64'(tx_valid), 0);
    @(negedge clk);
    check(tx_valid == 1 && tx_src == ME, "R4", "insert src", 64'(tx_src), 64'(ME));
    check(tx_len == 1 && tx_addr == 12 && tx_lock == 0 && tx_mon == 0, "R4", "insert header",
          {tx_lock, tx_mon, tx_addr, tx_len}, 64'd12);
    check(tx_data[31:0] == 32'hCAFE0012, "R4", "insert data", 64'(tx_data[31:0]), 64'hCAFE0012);
    check(tx_chk == ref_chk(ME, 0, 0, 12, 1, tx_data), "R12", "insert chk", 64'(tx_chk),
          64'(ref_chk(ME, 0, 0, 12, 1, tx_data)));
    shadow[12] = 32'hCAFE0012;
    rd(12, "R4", shadow[12]);

    // R6 / R7 lock write with round-trip timing, looped back after a delay
    @(negedge clk);
    host_we = 1; host_lock = 1; host_mon = 1; host_waddr = 25; host_wdata = 32'h10C4ED25;
    @(negedge clk);
    host_we = 0; host_lock = 0; host_mon = 0;
    @(negedge clk);
    c1 = cyc;
    cs = tx_src; cl = tx_lock; cm = tx_mon; ca = tx_addr; cn = tx_len; cd = tx_data; cc = tx_chk;
    check(tx_valid == 1 && cs == ME && cl == 1 && cm == 1, "R4", "lock/mon flags copied",
          {cs, 6'b0, cl, cm}, {ME, 8'h03});
    rd(25, "R6", shadow[25]);
    @(negedge clk);
    rx_valid = 1; rx_src = cs; rx_lock = cl; rx_mon = cm; rx_addr = ca;
    rx_len = cn; rx_data = cd; rx_chk = cc;
    exp_lat = cyc + 1 - c1;
    @(negedge clk);
    rx_valid = 0;
    check(tx_valid == 0, "R2", "returned own not forwarded", 64'(tx_valid), 0);
    check(mon_done == 1, "R7", "mon_done pulse", 64'(mon_done), 1);
    check(int'(mon_lat) == exp_lat, "R7", "round trip", 64'(mon_lat), 64'(exp_lat));
    @(negedge clk);
    check(mon_done == 0, "R7", "mon_done single", 64'(mon_done), 0);
    shadow[25] = 32'h10C4ED25;
    rd(25, "R6", shadow[25]);

    // R5 queue fills while the ring is busy; fifth write ignored
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (k > 0) begin
        check(tx_valid == 1 && tx_src != ME, "R5", "forward wins slot", 64'(tx_src), 64'd9);
      end
      if (k == 4) check(host_full == 1, "R5", "full after four", 64'(host_full), 1);
      d = gen_data(100 + k, 1);
      drive_rx(8'd9, 0, 0, 40 + k, 1, d, 1'b0);
      shadow[40 + k] = gen_word(100 + k, 0);
      host_we = (k < 5); host_lock = 0; host_mon = 0;
      host_waddr = AW'(10 + k); host_wdata = 32'hB0B00000 | 32'(k);
      if (k < 4) shadow[10 + k] = 32'hB0B00000 | 32'(k);
    end
    @(negedge clk);
    check(tx_valid == 1 && tx_src != ME, "R5", "last forward", 64'(tx_src), 64'd9);
    rx_valid = 0; host_we = 0;
    own_cnt = 0;
    repeat (8) begin
      @(negedge clk);
      if (tx_valid && tx_src == ME) own_cnt++;
    end
    check(own_cnt == 4, "R5", "inserted packet count", 64'(own_cnt), 64'd4);
    check(host_full == 0, "R5", "drained", 64'(host_full), 0);
    rd(14, "R5", shadow[14]);
    rd(13, "R5", shadow[13]);
    rd(43, "R1", shadow[43]);

    // R9 same-word collision: ring data kept
    d = gen_data(7, 1);
    @(negedge clk);
    drive_rx(8'd9, 0, 0, 20, 1, d, 1'b0);
    host_we = 1; host_lock = 0; host_mon = 0; host_waddr = 20; host_wdata = 32'h0BAD0020;
    @(negedge clk);
    rx_valid = 0; host_we = 0;
    check(tx_valid == 1 && tx_src == 8'd9, "R9", "forward in collision", 64'(tx_src), 64'd9);
    shadow[20] = gen_word(7, 0);
    repeat (3) @(negedge clk);
    rd(20, "R9", shadow[20]);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule